// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block listens passively on a four-wire SPI link between a host and a network controller whose control registers are split into four banks. It never drives the bus. While chip select is low it builds MOSI and MISO bytes from the serial lines, sampling both on each rising SCK edge (mode 0). It keeps only what the classification needs: the first MOSI byte, the second MOSI byte, the MISO byte of the most recent complete byte, and a byte count.

When chip select returns high, the monitor emits a single-cycle report. The report holds the command class and register address taken from the first byte, the register bank in force when the frame started, whether that bank is fully known, the frame length, a data byte and a vector of rule violations. The monitor follows the bank by watching commands aimed at the bank-select register. It is intended for protocol checkers, trace capture and bring-up logic that has to flag malformed host traffic in hardware.

The SPI inputs are taken to be synchronous to `clk` and much slower than it.

Top module: `spi_frame_monitor`

## Requirements
- R1: The cycle after the first clock edge that sees `spi_cs_n` high following a low period, `rpt_valid` pulses high for exactly one cycle. `rpt_count` holds the number of complete bytes, `rpt_opcode` holds bits 7:5 of the first MOSI byte and `rpt_addr` holds bits 4:0. A frame with no complete byte produces no report.
- R2: Opcode 3'b110 sets flag bit 0 (unknown command). No other flag from bits 0 to 4 is set for that frame.
- R3: Opcode 3'b001 needs the first byte to be exactly 0x3A, and opcode 3'b011 needs exactly 0x7A. Any other first byte with these opcodes sets flag bit 1 (bad header).
- R4: Flag bit 2 (bad length) is set when the frame length breaks its opcode's rule. Opcode 3'b000 must be 2 or 3 bytes. Opcodes 3'b010, 3'b100 and 3'b101 must be exactly 2 bytes. Opcode 3'b111 must be exactly 1 byte.
- R5: A correctly sized opcode-3'b000 frame sent while the bank is known sets flag bit 3 (dummy-byte mismatch) in two cases. The first is a MAC/MII-class register with a length other than 3. The second is any other register with a length other than 2. By default the MAC/MII class covers bank 2 addresses 0x00–0x0A and 0x12–0x19, and bank 3 addresses 0x00–0x06 and 0x0A.
- R6: A correctly sized opcode-3'b010 frame to address 0x1F loads the bank bits from data bits 1:0 and marks both bits known. A frame of wrong length, or one to any other address, leaves the bank unchanged. `rpt_bank` always reports the bank as it was before the frame.
- R7: A correctly sized opcode-3'b100 or 3'b101 frame to address 0x1F sets or clears each bank bit whose mask bit (data bits 1:0) is 1, and marks that bit known. The other bank bit keeps its value and its known state.
- R8: After reset both bank bits read 0 and are unknown. `rpt_bank_known` is 1 only when both bits are known. A correctly sized opcode 3'b000, 3'b010, 3'b100 or 3'b101 frame sent while the bank is not fully known sets flag bit 4 (bank unknown).
- R9: For opcode 3'b000, `rpt_data` is the MISO byte at the last complete byte position. For every other opcode it is the second MOSI byte, or 0 when the frame has fewer than 2 bytes.
- R10: SCK rising edges left over after the last complete byte (1 to 7 bits) set flag bit 5 (partial byte) on the report.
- R11: During and after reset, `rpt_valid` is 0 and all report outputs are 0 until the first report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Observed chip select, active low |
| spi_sck | input | 1 | Observed serial clock |
| spi_mosi | input | 1 | Observed host-to-device data |
| spi_miso | input | 1 | Observed device-to-host data |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_opcode | output | 3 | Command class from first byte |
| rpt_addr | output | 5 | Register address from first byte |
| rpt_bank | output | 2 | Bank in force at frame start |
| rpt_bank_known | output | 1 | Both bank bits have been observed |
| rpt_count | output | CNT_W | Complete bytes in the frame (saturating) |
| rpt_data | output | 8 | Data byte per R9 |
| rpt_flags | output | 6 | Violation flags, bit positions per R2–R5, R8, R10 |

## Verification
The assertions assume the SPI lines are synchronous to `clk`. They also assume each SCK level and each chip-select level lasts at least two clock cycles, so every edge is seen once and a new report can never follow a report on the next cycle. The stimulus changes the SPI lines only on falling clock edges and holds each SCK phase and each chip-select gap for two or more cycles. Frames are sent in an order that passes through partly known, fully known and unchanged bank states. This order exercises the bank tracking and the dummy-byte rule against a separate behavioural model.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    localparam int FLAG_W  = 6;
    localparam int F_UNK   = 0;
    localparam int F_HDR   = 1;
    localparam int F_LEN   = 2;
    localparam int F_DUMMY = 3;
    localparam int F_BANK  = 4;
    localparam int F_PART  = 5;

    typedef enum logic [2:0] {
        OP_RD_CTRL = 3'b000,
        OP_RD_BUF  = 3'b001,
        OP_WR_CTRL = 3'b010,
        OP_WR_BUF  = 3'b011,
        OP_SET     = 3'b100,
        OP_CLR     = 3'b101,
        OP_RSV     = 3'b110,
        OP_RESET   = 3'b111
    } op_e;

    localparam logic [7:0] RD_BUF_HDR    = 8'h3A;
    localparam logic [7:0] WR_BUF_HDR    = 8'h7A;
    localparam logic [4:0] BANK_SEL_ADDR = 5'h1F;

endpackage

// File: rtl/spi_mon_shifter.sv
module spi_mon_shifter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             miso,
    output logic             frame_end,
    output logic             partial,
    output logic [7:0]       hdr,
    output logic [7:0]       mosi1,
    output logic [7:0]       miso_last,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             cs;
        logic             sck;
        logic [2:0]       bits;
        logic [7:0]       sh_m;
        logic [7:0]       sh_s;
        logic [7:0]       hdr;
        logic [7:0]       mosi1;
        logic [7:0]       miso_last;
        logic [CNT_W-1:0] cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic [7:0] m_nx, s_nx;
    logic       cs_fall, sck_rise;

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_n;
        st_d.sck = sck;
        cs_fall  = !cs_n && st_q.cs;
        sck_rise = sck && !st_q.sck;
        m_nx     = {st_q.sh_m[6:0], mosi};
        s_nx     = {st_q.sh_s[6:0], miso};
        if (cs_fall) begin
            st_d.bits  = '0;
            st_d.cnt   = '0;
            st_d.mosi1 = '0;
        end else if (!cs_n && sck_rise) begin
            st_d.sh_m = m_nx;
            st_d.sh_s = s_nx;
            st_d.bits = st_q.bits + 3'd1;
            if (st_q.bits == 3'd7) begin
                if (st_q.cnt == '0)
                    st_d.hdr = m_nx;
                if (st_q.cnt == CNT_W'(1))
                    st_d.mosi1 = m_nx;
                st_d.miso_last = s_nx;
                if (st_q.cnt != CNT_MAX)
                    st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.cs <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_end = cs_n && !st_q.cs && (st_q.cnt != '0);
    assign partial   = (st_q.bits != 3'd0);
    assign hdr       = st_q.hdr;
    assign mosi1     = st_q.mosi1;
    assign miso_last = st_q.miso_last;
    assign count     = st_q.cnt;

    // R1: the byte count cannot move while the device is deselected
    a_r1_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs && cs_n) |=> $stable(st_q.cnt));

    // R10: a new selection starts with no leftover bits
    a_r10_bits_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs && !cs_n) |=> !partial);

endmodule

// File: rtl/spi_mon_bank.sv
module spi_mon_bank
    import spi_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [2:0] op,
    input  logic [4:0] addr,
    input  logic [1:0] mask,
    output logic [1:0] bank,
    output logic [1:0] known
);
    typedef struct packed {
        logic [1:0] bank;
        logic [1:0] known;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd && addr == BANK_SEL_ADDR) begin
            case (op)
                OP_WR_CTRL: begin
                    st_d.bank  = mask;
                    st_d.known = 2'b11;
                end
                OP_SET: begin
                    st_d.bank  = st_q.bank | mask;
                    st_d.known = st_q.known | mask;
                end
                OP_CLR: begin
                    st_d.bank  = st_q.bank & ~mask;
                    st_d.known = st_q.known | mask;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank  = st_q.bank;
    assign known = st_q.known;

    // R7: once a bank bit is observed it stays observed
    a_r7_known_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(st_q.known[0]) && !$fell(st_q.known[1]));

    // R6: the bank only moves on a completed, well-formed frame
    a_r6_bank_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.bank));

endmodule

// File: rtl/spi_mon_classify.sv
module spi_mon_classify
    import spi_mon_pkg::*;
#(
    parameter int          CNT_W   = 8,
    parameter logic [127:0] MAC_MAP = {32'h0000_047F, 32'h03FC_07FF, 32'h0, 32'h0}
) (
    input  logic [7:0]        hdr,
    input  logic [7:0]        mosi1,
    input  logic [7:0]        miso_last,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        bank,
    input  logic [1:0]        known,
    input  logic              partial,
    output logic [2:0]        op,
    output logic [4:0]        addr,
    output logic [7:0]        data,
    output logic              len_ok,
    output logic [FLAG_W-1:0] flags
);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

    logic len_bad, bank_full, is_mac, reg_acc;

    always_comb begin
        op        = hdr[7:5];
        addr      = hdr[4:0];
        bank_full = &known;
        is_mac    = MAC_MAP[{bank, addr}];
        case (op)
            OP_RD_CTRL:               len_bad = (count != TWO) && (count != THREE);
            OP_WR_CTRL, OP_SET, OP_CLR: len_bad = (count != TWO);
            OP_RESET:                 len_bad = (count != ONE);
            default:                  len_bad = 1'b0;
        endcase
        len_ok  = !len_bad;
        reg_acc = !len_bad && (op == OP_RD_CTRL || op == OP_WR_CTRL ||
                               op == OP_SET || op == OP_CLR);

        flags          = '0;
        flags[F_UNK]   = (op == OP_RSV);
        flags[F_HDR]   = (op == OP_RD_BUF && hdr != RD_BUF_HDR) ||
                         (op == OP_WR_BUF && hdr != WR_BUF_HDR);
        flags[F_LEN]   = len_bad;
        flags[F_DUMMY] = (op == OP_RD_CTRL) && !len_bad && bank_full &&
                         (is_mac ? (count != THREE) : (count != TWO));
        flags[F_BANK]  = reg_acc && !bank_full;
        flags[F_PART]  = partial;

        data = (op == OP_RD_CTRL) ? miso_last : mosi1;
    end

endmodule

// File: rtl/spi_frame_monitor.sv
module spi_frame_monitor
    import spi_mon_pkg::*;
#(
    parameter int           CNT_W   = 8,
    parameter logic [127:0] MAC_MAP = {32'h0000_047F, 32'h03FC_07FF, 32'h0, 32'h0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_miso,
    output logic              rpt_valid,
    output logic [2:0]        rpt_opcode,
    output logic [4:0]        rpt_addr,
    output logic [1:0]        rpt_bank,
    output logic              rpt_bank_known,
    output logic [CNT_W-1:0]  rpt_count,
    output logic [7:0]        rpt_data,
    output logic [FLAG_W-1:0] rpt_flags
);
    logic              frame_end, partial, len_ok;
    logic [7:0]        hdr, mosi1, miso_last, cls_data;
    logic [CNT_W-1:0]  count;
    logic [1:0]        bank, known;
    logic [2:0]        cls_op;
    logic [4:0]        cls_addr;
    logic [FLAG_W-1:0] cls_flags;

    spi_mon_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
        .mosi(spi_mosi), .miso(spi_miso), .frame_end(frame_end),
        .partial(partial), .hdr(hdr), .mosi1(mosi1),
        .miso_last(miso_last), .count(count)
    );

    spi_mon_classify #(.CNT_W(CNT_W), .MAC_MAP(MAC_MAP)) u_cls (
        .hdr(hdr), .mosi1(mosi1), .miso_last(miso_last), .count(count),
        .bank(bank), .known(known), .partial(partial), .op(cls_op),
        .addr(cls_addr), .data(cls_data), .len_ok(len_ok), .flags(cls_flags)
    );

    spi_mon_bank u_bank (
        .clk(clk), .rst_n(rst_n), .upd(frame_end && len_ok), .op(cls_op),
        .addr(cls_addr), .mask(mosi1[1:0]), .bank(bank), .known(known)
    );

    typedef struct packed {
        logic              valid;
        logic [2:0]        op;
        logic [4:0]        addr;
        logic [1:0]        bank;
        logic              known;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        data;
        logic [FLAG_W-1:0] flags;
    } rpt_st_t;

    rpt_st_t rpt_d, rpt_q;

    always_comb begin
        rpt_d       = rpt_q;
        rpt_d.valid = frame_end;
        if (frame_end) begin
            rpt_d.op    = cls_op;
            rpt_d.addr  = cls_addr;
            rpt_d.bank  = bank;
            rpt_d.known = &known;
            rpt_d.cnt   = count;
            rpt_d.data  = cls_data;
            rpt_d.flags = cls_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rpt_q <= '0;
        else        rpt_q <= rpt_d;
    end

    assign rpt_valid      = rpt_q.valid;
    assign rpt_opcode     = rpt_q.op;
    assign rpt_addr       = rpt_q.addr;
    assign rpt_bank       = rpt_q.bank;
    assign rpt_bank_known = rpt_q.known;
    assign rpt_count      = rpt_q.cnt;
    assign rpt_data       = rpt_q.data;
    assign rpt_flags      = rpt_q.flags;

    // R1: a report strobe lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);

    // R2: the unknown command flag stands alone among bits 4:0
    a_r2_unknown_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_opcode == 3'b110) |-> (rpt_flags[4:0] == 5'b00001));

    // R3: header errors only come from buffer commands
    a_r3_header_buffer_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_HDR]) |-> (rpt_opcode == 3'b001 || rpt_opcode == 3'b011));

    // R5: dummy-byte mismatch needs a known bank and a control read
    a_r5_dummy_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_DUMMY]) |-> (rpt_bank_known && rpt_opcode == 3'b000));

    // R8: bank-unknown flag never accompanies a known bank
    a_r8_bank_flag_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_BANK]) |-> !rpt_bank_known);

endmodule

// File: tb/test_spi_frame_monitor.sv
`timescale 1ns/1ps
module test_spi_frame_monitor;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, cs_n, sck, mosi, miso;
    logic       rpt_valid, rpt_bank_known;
    logic [2:0] rpt_opcode;
    logic [4:0] rpt_addr;
    logic [1:0] rpt_bank;
    logic [7:0] rpt_count, rpt_data;
    logic [5:0] rpt_flags;

    spi_frame_monitor i_spi_frame_monitor (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .rpt_valid(rpt_valid),
        .rpt_opcode(rpt_opcode), .rpt_addr(rpt_addr), .rpt_bank(rpt_bank),
        .rpt_bank_known(rpt_bank_known), .rpt_count(rpt_count),
        .rpt_data(rpt_data), .rpt_flags(rpt_flags)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  tm[16];
    logic [7:0]  ts[16];
    bit          mb0 = 0, mb1 = 0, mk0 = 0, mk1 = 0;
    logic [32:0] act, expv;
    string       tg;

    function automatic bit mac_reg(int bk, int a);
        if (bk == 2) return (a <= 10) || (a >= 18 && a <= 25);
        if (bk == 3) return (a <= 6) || (a == 10);
        return 0;
    endfunction

    // reference model: expected report and bank update for one frame
    task automatic model(int n, int extra, string tag);
        int op, a, bk, dat;
        bit kn, lbad, racc;
        logic [5:0] fl;
        op = tm[0][7:5]; a = tm[0][4:0];
        bk = {mb1, mb0}; kn = mk0 && mk1;
        if (op == 0)                        lbad = (n != 2 && n != 3);
        else if (op == 2 || op == 4 || op == 5) lbad = (n != 2);
        else if (op == 7)                   lbad = (n != 1);
        else                                lbad = 0;
        racc = !lbad && (op == 0 || op == 2 || op == 4 || op == 5);
        fl = 0;
        fl[0] = (op == 6);
        fl[1] = (op == 1 && tm[0] != 8'h3A) || (op == 3 && tm[0] != 8'h7A);
        fl[2] = lbad;
        fl[3] = (op == 0) && !lbad && kn && (mac_reg(bk, a) ? (n != 3) : (n != 2));
        fl[4] = racc && !kn;
        fl[5] = (extra != 0);
        if (op == 0) dat = ts[n-1];
        else         dat = (n >= 2) ? tm[1] : 0;
        exp_q.push_back({op[2:0], a[4:0], bk[1:0], kn, n[7:0], dat[7:0], fl});
        tag_q.push_back(tag);
        if (!lbad && a == 31) begin
            if (op == 2) begin
                mb0 = tm[1][0]; mb1 = tm[1][1]; mk0 = 1; mk1 = 1;
            end else if (op == 4 || op == 5) begin
                if (tm[1][0]) begin mb0 = (op == 4); mk0 = 1; end
                if (tm[1][1]) begin mb1 = (op == 4); mk1 = 1; end
            end
        end
    endtask

    task automatic spi_bit(bit m, bit s);
        @(negedge clk); mosi = m; miso = s;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame(int n, int extra, string tag);
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--)
                spi_bit(tm[i][b], ts[i][b]);
        for (int e = 0; e < extra; e++)
            spi_bit(1'b1, 1'b0);
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        if (n > 0) model(n, extra, tag);
        repeat (4) @(negedge clk);
    endtask

    task automatic set2(logic [7:0] m0, logic [7:0] m1, logic [7:0] s1);
        tm[0] = m0; tm[1] = m1; ts[0] = 8'h00; ts[1] = s1;
    endtask

    // per-clock comparison against the model queue
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (rpt_valid) begin
                checks++;
                act = {rpt_opcode, rpt_addr, rpt_bank, rpt_bank_known,
                       rpt_count, rpt_data, rpt_flags};
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected report got=%h exp=none", act);
                end else begin
                    expv = exp_q.pop_front();
                    tg   = tag_q.pop_front();
                    if (act !== expv) begin
                        fails++;
                        $display("FAIL %s report got=%h exp=%h", tg, act, expv);
                    end
                end
            end else if (exp_q.size() != 0) begin
                checks++; fails++;
                $display("FAIL R1 missing report got=none exp=%h", exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; miso = 1'b0;
        repeat (4) @(negedge clk);
        checks++; // R11: outputs in reset
        if ({rpt_valid, rpt_opcode, rpt_addr, rpt_bank, rpt_bank_known,
             rpt_count, rpt_data, rpt_flags} !== '0) begin
            fails++;
            $display("FAIL R11 reset outputs got=%b exp=0", rpt_valid);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (rpt_valid !== 1'b0 || rpt_bank_known !== 1'b0) begin
            fails++;
            $display("FAIL R11 after reset got=%b%b exp=00", rpt_valid, rpt_bank_known);
        end

        set2(8'h05, 8'h00, 8'hA5); frame(2, 0, "R8 read with bank unknown");
        set2(8'h9F, 8'h01, 8'h00); frame(2, 0, "R7 set bit0 of bank select");
        set2(8'h05, 8'h00, 8'h3C); frame(2, 0, "R7 bank half known");
        set2(8'hBF, 8'h02, 8'h00); frame(2, 0, "R7 clear bit1 of bank select");
        set2(8'h00, 8'h00, 8'h5A); frame(2, 0, "R9 plain read data");
        set2(8'h5F, 8'h02, 8'h00); frame(2, 0, "R6 write bank select");
        set2(8'h00, 8'h00, 8'h11); frame(2, 0, "R5 MAC read without dummy");
        set2(8'h12, 8'h00, 8'h00); ts[2] = 8'hC3; frame(3, 0, "R5 MAC read with dummy");
        set2(8'h1B, 8'h00, 8'h00); ts[2] = 8'h77; frame(3, 0, "R5 plain read with dummy");
        set2(8'h5F, 8'h01, 8'h00); tm[2] = 8'h00; frame(3, 0, "R4 long write ignored");
        set2(8'h00, 8'h00, 8'h00); tm[2] = 8'h00; ts[2] = 8'h99; frame(3, 0, "R6 bank kept after bad write");
        set2(8'h00, 8'h00, 8'h00); tm[2] = 8'h00; ts[2] = 8'h00; tm[3] = 8'h00; frame(4, 0, "R4 read too long");
        set2(8'h3A, 8'hDE, 8'h00); tm[2] = 8'hAD; frame(3, 0, "R3 read buffer good header");
        set2(8'h3B, 8'h44, 8'h00); frame(2, 0, "R3 read buffer bad header");
        set2(8'h7A, 8'h66, 8'h00); frame(2, 0, "R3 write buffer good header");
        set2(8'h7B, 8'h66, 8'h00); frame(2, 0, "R3 write buffer bad header");
        set2(8'hFF, 8'h00, 8'h00); frame(1, 0, "R4 reset command single byte");
        set2(8'hFF, 8'h12, 8'h00); frame(2, 0, "R4 reset command too long");
        set2(8'hC0, 8'h34, 8'h00); frame(2, 0, "R2 unknown opcode");
        set2(8'h5F, 8'h03, 8'h00); frame(2, 3, "R10 partial byte on bank write");
        frame(0, 5, "R1 no complete byte");
        set2(8'h5E, 8'h00, 8'h00); frame(2, 0, "R6 write to other address");
        set2(8'h0A, 8'h00, 8'h00); ts[2] = 8'h2B; frame(3, 0, "R5 bank3 MAC read");
        set2(8'h9F, 8'h00, 8'h00); frame(2, 0, "R7 zero mask set");
        set2(8'h4A, 8'hE1, 8'h00); frame(2, 0, "R1 bank3 write fields");

        repeat (6) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 pending reports got=%0d exp=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule